// File: doc/BRIEF.md
# Bulk Row Copy Command Sequencer

This memory-controller block turns a bulk copy or initialise request into a stream of DRAM commands. A request gives a source row address, a destination row address and a length in bytes. The block first asks the cache hierarchy to flush the affected lines and waits for the acknowledge. It then walks the request one row-sized chunk at a time. Each chunk's source and destination rows are compared on their bank and subarray fields.

A chunk that covers a whole row, with both rows in the same subarray, is copied in place through the shared sense amplifiers. The block issues two activates back to back, first the source row and then the destination row, followed by a precharge. Any other chunk falls back to a serial sequence: both rows are opened, one transfer command is issued per cache line, and the chunk is closed with a precharge. This applies to rows in different subarrays or banks, and to a partial final chunk.

Every issued command loads a gap counter from the programmable gap of its own type, and the next command waits until that counter is empty. An initialise request copies from a reserved all-zero row, which is row 0 of the destination chunk's subarray.

Top module: `bulk_copy_seq`

## Requirements
- R1: After reset, req_ready_o is 1 and cmd_valid_o, flush_req_o and done_o are 0. req_ready_o is 1 only while the block is idle, and a request is accepted on a cycle with req_valid_i and req_ready_o both high.
- R2: After a request with non-zero length is accepted, flush_req_o stays high until flush_ack_i is seen. No command is issued while it is high. While it is high, flush_src_o, flush_dst_o and flush_len_o show the first chunk's source row, the destination row and the full length.
- R3: A length of L bytes is split into ceil(L/ROW_BYTES) chunks. Chunk k uses source row src+k and destination row dst+k. Row addresses increment as plain binary numbers and wrap at the top.
- R4: A row address holds the bank in its top BK_W bits, the subarray in the next SA_W bits and the row within the subarray in its low ROW_W bits. Two rows are co-located when their bank and subarray bits are equal.
- R5: A chunk that is co-located and holds at least ROW_BYTES bytes produces exactly ACT(source row), ACT(destination row), PRE(destination row).
- R6: Any other chunk produces ACT(source), ACT(destination), then n XFER commands with line index 0 to n-1, then PRE(destination). Here n = ROW_BYTES/LINE_BYTES for a full chunk and ceil(bytes/LINE_BYTES) for a partial last chunk.
- R7: Within a request, a command follows the previous one after exactly g+1 cycles. g is gap_act_i after an ACT, gap_xfer_i after an XFER and gap_pre_i after a PRE.
- R8: done_o is high for exactly one cycle per request. For a non-empty request, that cycle is the one in which the last PRE appears on the command outputs.
- R9: A request with zero length raises no flush and issues no command. done_o is high in the cycle right after the accepting clock edge.
- R10: For an initialise request (req_init_i = 1), the source row of every chunk is row 0 of the destination chunk's bank and subarray. The source row input is ignored.
- R11: cmd_op_o encodes ACT as 1, PRE as 2 and XFER as 3. cmd_dst_row_o and cmd_line_o are 0 on every command other than XFER.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_init_i | input | 1 | 1: initialise destination with zeros |
| req_src_row_i | input | RA_W | Source row address |
| req_dst_row_i | input | RA_W | Destination row address |
| req_len_i | input | LEN_W | Length in bytes |
| gap_act_i | input | DLY_W | Idle cycles after an ACT |
| gap_xfer_i | input | DLY_W | Idle cycles after an XFER |
| gap_pre_i | input | DLY_W | Idle cycles after a PRE |
| flush_req_o | output | 1 | Cache flush request for the accepted range |
| flush_ack_i | input | 1 | Cache flush complete |
| flush_src_o | output | RA_W | First source row of the range |
| flush_dst_o | output | RA_W | First destination row of the range |
| flush_len_o | output | LEN_W | Length of the range in bytes |
| cmd_valid_o | output | 1 | Command issued this cycle |
| cmd_op_o | output | 2 | Command code |
| cmd_row_o | output | RA_W | Row addressed by the command |
| cmd_dst_row_o | output | RA_W | Destination row of an XFER |
| cmd_line_o | output | LI_W | Cache line index of an XFER |
| done_o | output | 1 | Request finished |

## Verification
Command registers update on the issuing edge. The first ACT of a request comes one clock edge after the flush acknowledge is taken, or later if a gap from earlier is still running. Each later command follows g+1 edges after the one before it. done_o rises with the final PRECHARGE, and for an empty request it is visible right after the accepting edge. The bench samples every output on the falling edge and tags each command with a cycle number. It then compares the recorded stream with a sequence computed from row arithmetic: the order, the fields, the spacing between consecutive commands, and the cycle of done_o against the cycle of the last PRECHARGE. It sweeps every source and destination row pair of a small geometry, a set of lengths around the row and line boundaries, and both request kinds.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_ACT  = 2'd1,
    CMD_PRE  = 2'd2,
    CMD_XFER = 2'd3
  } bcs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_ACT_S,
    ST_ACT_D,
    ST_XFER,
    ST_PRE,
    ST_DONE
  } bcs_state_e;
endpackage

// File: rtl/bcs_gap_timer.sv
module bcs_gap_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] gap_i,
  output logic             idle_o
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= gap_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/bcs_row_map.sv
// Resolves the effective source row and the co-location test.
module bcs_row_map #(
  parameter int RA_W  = 8,
  parameter int ROW_W = 4
) (
  input  logic            init_i,
  input  logic [RA_W-1:0] src_row_i,
  input  logic [RA_W-1:0] dst_row_i,
  output logic [RA_W-1:0] src_row_o,
  output logic            coloc_o
);
  localparam int LOC_W = RA_W - ROW_W;

  logic [LOC_W-1:0] dst_loc;
  logic [LOC_W-1:0] src_loc;

  assign dst_loc   = dst_row_i[RA_W-1:ROW_W];
  // zero row: index 0 inside the destination subarray
  assign src_row_o = init_i ? {dst_loc, {ROW_W{1'b0}}} : src_row_i;
  assign src_loc   = src_row_o[RA_W-1:ROW_W];
  assign coloc_o   = (src_loc == dst_loc);
endmodule

// File: rtl/bcs_chunk_walk.sv
module bcs_chunk_walk #(
  parameter int RA_W       = 8,
  parameter int LEN_W      = 16,
  parameter int ROW_BYTES  = 4096,
  parameter int LINE_BYTES = 64
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         load_i,
  input  logic [RA_W-1:0]                              src_row_i,
  input  logic [RA_W-1:0]                              dst_row_i,
  input  logic [LEN_W-1:0]                             len_i,
  input  logic                                         adv_i,
  output logic [RA_W-1:0]                              src_row_o,
  output logic [RA_W-1:0]                              dst_row_o,
  output logic [LEN_W-1:0]                             rem_o,
  output logic                                         full_o,
  output logic                                         last_o,
  output logic [$clog2(ROW_BYTES/LINE_BYTES)-1:0]      last_line_o
);
  localparam int LINE_SH = $clog2(LINE_BYTES);
  localparam int LI_W    = $clog2(ROW_BYTES / LINE_BYTES);
  localparam logic [LEN_W-1:0] ROW_L = LEN_W'(ROW_BYTES);

  logic [RA_W-1:0]  src_q, dst_q;
  logic [LEN_W-1:0] rem_q;
  logic [LEN_W-1:0] chunk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      src_q <= src_row_i;
      dst_q <= dst_row_i;
      rem_q <= len_i;
    end else if (adv_i) begin
      src_q <= src_q + 1'b1;
      dst_q <= dst_q + 1'b1;
      rem_q <= full_o ? rem_q - ROW_L : '0;
    end
  end

  assign full_o      = (rem_q >= ROW_L);
  assign last_o      = (rem_q <= ROW_L);
  assign chunk       = full_o ? ROW_L : rem_q;
  assign last_line_o = LI_W'((chunk - 1'b1) >> LINE_SH);
  assign src_row_o   = src_q;
  assign dst_row_o   = dst_q;
  assign rem_o       = rem_q;
endmodule

// File: rtl/bulk_copy_seq.sv
module bulk_copy_seq
  import bcs_pkg::*;
#(
  parameter int ROW_BYTES  = 4096,
  parameter int LINE_BYTES = 64,
  parameter int ROW_W      = 4,
  parameter int SA_W       = 2,
  parameter int BK_W       = 2,
  parameter int LEN_W      = 16,
  parameter int DLY_W      = 8,
  localparam int RA_W      = BK_W + SA_W + ROW_W,
  localparam int LI_W      = $clog2(ROW_BYTES / LINE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_init_i,
  input  logic [RA_W-1:0]  req_src_row_i,
  input  logic [RA_W-1:0]  req_dst_row_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [DLY_W-1:0] gap_act_i,
  input  logic [DLY_W-1:0] gap_xfer_i,
  input  logic [DLY_W-1:0] gap_pre_i,
  output logic             flush_req_o,
  input  logic             flush_ack_i,
  output logic [RA_W-1:0]  flush_src_o,
  output logic [RA_W-1:0]  flush_dst_o,
  output logic [LEN_W-1:0] flush_len_o,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic [RA_W-1:0]  cmd_row_o,
  output logic [RA_W-1:0]  cmd_dst_row_o,
  output logic [LI_W-1:0]  cmd_line_o,
  output logic             done_o
);
  bcs_state_e        state_q;
  logic              init_q;
  logic [LI_W-1:0]   line_q;

  logic              accept, issue, gap_idle, adv;
  logic [RA_W-1:0]   src_raw, src_eff, dst_row;
  logic [LEN_W-1:0]  rem;
  logic              coloc, full, last;
  logic [LI_W-1:0]   last_line;

  bcs_op_e           nxt_op;
  logic [RA_W-1:0]   nxt_row, nxt_drow;
  logic [LI_W-1:0]   nxt_line;
  logic [DLY_W-1:0]  nxt_gap;

  logic              cmd_valid_q;
  bcs_op_e           cmd_op_q;
  logic [RA_W-1:0]   cmd_row_q, cmd_drow_q;
  logic [LI_W-1:0]   cmd_line_q;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign adv    = issue && (state_q == ST_PRE);

  bcs_chunk_walk #(
    .RA_W(RA_W), .LEN_W(LEN_W), .ROW_BYTES(ROW_BYTES), .LINE_BYTES(LINE_BYTES)
  ) u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(accept), .src_row_i(req_src_row_i), .dst_row_i(req_dst_row_i),
    .len_i(req_len_i), .adv_i(adv),
    .src_row_o(src_raw), .dst_row_o(dst_row), .rem_o(rem),
    .full_o(full), .last_o(last), .last_line_o(last_line)
  );

  bcs_row_map #(.RA_W(RA_W), .ROW_W(ROW_W)) u_map (
    .init_i(init_q), .src_row_i(src_raw), .dst_row_i(dst_row),
    .src_row_o(src_eff), .coloc_o(coloc)
  );

  bcs_gap_timer #(.DLY_W(DLY_W)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(issue), .gap_i(nxt_gap), .idle_o(gap_idle)
  );

  always_comb begin
    issue    = 1'b0;
    nxt_op   = CMD_NOP;
    nxt_row  = '0;
    nxt_drow = '0;
    nxt_line = '0;
    nxt_gap  = '0;
    if (gap_idle) begin
      case (state_q)
        ST_ACT_S: begin
          issue = 1'b1; nxt_op = CMD_ACT; nxt_row = src_eff; nxt_gap = gap_act_i;
        end
        ST_ACT_D: begin
          issue = 1'b1; nxt_op = CMD_ACT; nxt_row = dst_row; nxt_gap = gap_act_i;
        end
        ST_XFER: begin
          issue = 1'b1; nxt_op = CMD_XFER; nxt_row = src_eff; nxt_drow = dst_row;
          nxt_line = line_q; nxt_gap = gap_xfer_i;
        end
        ST_PRE: begin
          issue = 1'b1; nxt_op = CMD_PRE; nxt_row = dst_row; nxt_gap = gap_pre_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      init_q  <= 1'b0;
      line_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          init_q  <= req_init_i;
          state_q <= (req_len_i == '0) ? ST_DONE : ST_FLUSH;
        end
        ST_FLUSH: if (flush_ack_i) state_q <= ST_ACT_S;
        ST_ACT_S: if (issue) state_q <= ST_ACT_D;
        ST_ACT_D: if (issue) begin
          line_q  <= '0;
          // in-array copy needs a whole row inside one subarray
          state_q <= (coloc && full) ? ST_PRE : ST_XFER;
        end
        ST_XFER: if (issue) begin
          if (line_q == last_line) state_q <= ST_PRE;
          else                     line_q  <= line_q + 1'b1;
        end
        ST_PRE: if (issue) state_q <= last ? ST_DONE : ST_ACT_S;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= CMD_NOP;
      cmd_row_q   <= '0;
      cmd_drow_q  <= '0;
      cmd_line_q  <= '0;
    end else begin
      cmd_valid_q <= issue;
      cmd_op_q    <= nxt_op;
      cmd_row_q   <= nxt_row;
      cmd_drow_q  <= nxt_drow;
      cmd_line_q  <= nxt_line;
    end
  end

  assign req_ready_o   = (state_q == ST_IDLE);
  assign flush_req_o   = (state_q == ST_FLUSH);
  assign flush_src_o   = src_eff;
  assign flush_dst_o   = dst_row;
  assign flush_len_o   = rem;
  assign cmd_valid_o   = cmd_valid_q;
  assign cmd_op_o      = cmd_op_q;
  assign cmd_row_o     = cmd_row_q;
  assign cmd_dst_row_o = cmd_drow_q;
  assign cmd_line_o    = cmd_line_q;
  assign done_o        = (state_q == ST_DONE);
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker
  import bcs_pkg::*;
#(
  parameter int RA_W  = 8,
  parameter int LI_W  = 6,
  parameter int DLY_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             flush_req_o,
  input logic             flush_ack_i,
  input logic [DLY_W-1:0] gap_act_i,
  input logic [DLY_W-1:0] gap_xfer_i,
  input logic [DLY_W-1:0] gap_pre_i,
  input logic             cmd_valid_o,
  input logic [1:0]       cmd_op_o,
  input logic [RA_W-1:0]  cmd_dst_row_o,
  input logic [LI_W-1:0]  cmd_line_o,
  input logic             done_o
);
  logic [DLY_W:0] since_q, need_q;
  logic           seen_q;
  logic [DLY_W:0] gap_now;

  always_comb begin
    case (cmd_op_o)
      2'd1:    gap_now = {1'b0, gap_act_i} + 1'b1;
      2'd3:    gap_now = {1'b0, gap_xfer_i} + 1'b1;
      default: gap_now = {1'b0, gap_pre_i} + 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      need_q  <= '0;
      seen_q  <= 1'b0;
    end else if (cmd_valid_o) begin
      since_q <= 1;
      need_q  <= gap_now;
      seen_q  <= 1'b1;
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!cmd_valid_o && !flush_req_o));

  a_r2_flush_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_req_o && !flush_ack_i) |=> flush_req_o);

  a_r2_no_cmd_in_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> !cmd_valid_o);

  a_r7_min_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && seen_q) |-> (since_q >= need_q));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_on_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cmd_valid_o) |-> (cmd_op_o == 2'd2));

  a_r11_xfer_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o != 2'd3) |-> (cmd_line_o == '0 && cmd_dst_row_o == '0));
endmodule

bind bulk_copy_seq bcs_checker #(
  .RA_W(RA_W), .LI_W(LI_W), .DLY_W(DLY_W)
) u_bcs_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o),
  .flush_req_o(flush_req_o), .flush_ack_i(flush_ack_i),
  .gap_act_i(gap_act_i), .gap_xfer_i(gap_xfer_i), .gap_pre_i(gap_pre_i),
  .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o),
  .cmd_dst_row_o(cmd_dst_row_o), .cmd_line_o(cmd_line_o), .done_o(done_o)
);

// File: tb/tb_bulk_copy_seq.sv
module tb_bulk_copy_seq;
  localparam int ROW_BYTES = 256, LINE_BYTES = 64, ROW_W = 2, SA_W = 1, BK_W = 1;
  localparam int LEN_W = 12, DLY_W = 4;
  localparam int RA_W = BK_W + SA_W + ROW_W, LI_W = 2;
  localparam int NROWS = 1 << RA_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             req_valid = 0, req_init = 0, flush_ack = 0;
  logic [RA_W-1:0]  req_src = '0, req_dst = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [DLY_W-1:0] g_act = '0, g_xfer = '0, g_pre = '0;
  logic             req_ready_o, flush_req_o, cmd_valid_o, done_o;
  logic [RA_W-1:0]  flush_src_o, flush_dst_o, cmd_row_o, cmd_dst_row_o;
  logic [LEN_W-1:0] flush_len_o;
  logic [1:0]       cmd_op_o;
  logic [LI_W-1:0]  cmd_line_o;

  bulk_copy_seq #(.ROW_BYTES(ROW_BYTES), .LINE_BYTES(LINE_BYTES), .ROW_W(ROW_W),
    .SA_W(SA_W), .BK_W(BK_W), .LEN_W(LEN_W), .DLY_W(DLY_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_init_i(req_init), .req_src_row_i(req_src), .req_dst_row_i(req_dst),
    .req_len_i(req_len), .gap_act_i(g_act), .gap_xfer_i(g_xfer), .gap_pre_i(g_pre),
    .flush_req_o(flush_req_o), .flush_ack_i(flush_ack), .flush_src_o(flush_src_o),
    .flush_dst_o(flush_dst_o), .flush_len_o(flush_len_o), .cmd_valid_o(cmd_valid_o),
    .cmd_op_o(cmd_op_o), .cmd_row_o(cmd_row_o), .cmd_dst_row_o(cmd_dst_row_o),
    .cmd_line_o(cmd_line_o), .done_o(done_o));

  int checks = 0, errors = 0, cyc = 0;
  int rec_pk[0:255], rec_cyc[0:255], rec_n = 0;
  int exp_pk[0:255], exp_op[0:255], exp_n = 0;
  int done_cnt = 0, done_cyc = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected < %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid_o) begin
      if (rec_n < 256) begin
        rec_pk[rec_n]  = int'(cmd_op_o) * 4096 + int'(cmd_row_o) * 256
                       + int'(cmd_dst_row_o) * 16 + int'(cmd_line_o);
        rec_cyc[rec_n] = cyc;
      end
      rec_n++;
    end
    if (done_o) begin done_cnt++; done_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic push(input int op, input int row, input int drow, input int line);
    exp_op[exp_n] = op;
    exp_pk[exp_n] = op * 4096 + row * 256 + drow * 16 + line;
    exp_n++;
  endtask

  // R3 R4 R5 R6 R10 R11: reference stream from row arithmetic
  task automatic build_exp(input bit init, input int src, input int dst, input int len, output int first_src);
    int s = src, d = dst, rem = len, cb, sr, nl;
    bit col, full;
    exp_n = 0;
    first_src = init ? ((dst >> ROW_W) << ROW_W) : src;
    while (rem > 0) begin
      full = (rem >= ROW_BYTES);
      cb   = full ? ROW_BYTES : rem;
      sr   = init ? ((d >> ROW_W) << ROW_W) : s;
      col  = ((sr >> ROW_W) == (d >> ROW_W));
      push(1, sr, 0, 0);
      push(1, d, 0, 0);
      if (!(col && full)) begin
        nl = (cb + LINE_BYTES - 1) / LINE_BYTES;
        for (int l = 0; l < nl; l++) push(3, sr, d, l);
      end
      push(2, d, 0, 0);
      s = (s + 1) % NROWS;
      d = (d + 1) % NROWS;
      rem -= cb;
    end
  endtask

  function automatic int gap_of(input int op, input int ga, input int gx, input int gp);
    return (op == 1) ? ga : (op == 3) ? gx : gp;
  endfunction

  task automatic run_req(input bit init, input int src, input int dst, input int len,
                         input int ga, input int gx, input int gp, input int ackd);
    int fs, acc, to;
    bit bad;
    build_exp(init, src, dst, len, fs);
    g_act = DLY_W'(ga); g_xfer = DLY_W'(gx); g_pre = DLY_W'(gp);
    rec_n = 0; done_cnt = 0;
    chk(req_ready_o == 1'b1, "R1", "ready before request", int'(req_ready_o), 1);
    req_valid = 1; req_init = init; req_src = RA_W'(src); req_dst = RA_W'(dst);
    req_len = LEN_W'(len);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    acc = cyc;
    if (len == 0) begin
      chk(done_o == 1'b1 && flush_req_o == 1'b0, "R9", "empty request done/flush",
          int'(done_o) * 2 + int'(flush_req_o), 2);
      repeat (4) @(negedge clk);
      #1;
      chk(rec_n == 0 && done_cnt == 1 && done_cyc == acc, "R9", "empty request cmds/done cycle",
          rec_n * 1000 + done_cyc - acc, 0);
      return;
    end
    chk(flush_req_o == 1'b1 && req_ready_o == 1'b0, "R2", "flush raised, busy",
        int'(flush_req_o) * 2 + int'(req_ready_o), 2);
    chk(int'(flush_src_o) == fs, init ? "R10" : "R2", "flush source row", int'(flush_src_o), fs);
    chk(int'(flush_dst_o) == dst && int'(flush_len_o) == len, "R2", "flush dst*4096+len",
        int'(flush_dst_o) * 4096 + int'(flush_len_o), dst * 4096 + len);
    bad = 0;
    for (int i = 0; i < ackd; i++) begin
      @(negedge clk);
      if (!flush_req_o || cmd_valid_o) bad = 1;
    end
    chk(!bad, "R2", "flush held, no command before ack", int'(bad), 0);
    flush_ack = 1;
    @(negedge clk);
    flush_ack = 0;
    to = 0;
    while (!done_o && to < 3000) begin @(negedge clk); to++; end
    repeat (5) @(negedge clk);
    #1;
    chk(rec_n == exp_n, "R3", "command count", rec_n, exp_n);
    for (int j = 0; j < exp_n && j < rec_n; j++) begin
      chk(rec_pk[j] == exp_pk[j], "R3 R4 R5 R6 R10 R11", "command op:row:dst:line", rec_pk[j], exp_pk[j]);
      if (j > 0)
        chk(rec_cyc[j] - rec_cyc[j-1] == gap_of(exp_op[j-1], ga, gx, gp) + 1, "R7",
            "command spacing", rec_cyc[j] - rec_cyc[j-1], gap_of(exp_op[j-1], ga, gx, gp) + 1);
    end
    chk(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    if (rec_n > 0 && rec_n <= 256)
      chk(done_cyc == rec_cyc[rec_n-1], "R8", "done cycle vs last PRE", done_cyc, rec_cyc[rec_n-1]);
  endtask

  initial begin
    int lens[12] = '{1, 63, 64, 65, 128, 200, 255, 257, 300, 511, 512, 700};
    int idx;
    repeat (3) @(negedge clk);
    chk(req_ready_o && !cmd_valid_o && !flush_req_o && !done_o, "R1", "reset state",
        int'(req_ready_o) * 8 + int'(cmd_valid_o) * 4 + int'(flush_req_o) * 2 + int'(done_o), 8);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready_o && !cmd_valid_o && !flush_req_o && !done_o, "R1", "idle after reset",
        int'(req_ready_o) * 8 + int'(cmd_valid_o) * 4 + int'(flush_req_o) * 2 + int'(done_o), 8);

    // R4 R5 R6: every row pair, one full row
    idx = 0;
    for (int s = 0; s < NROWS; s++)
      for (int d = 0; d < NROWS; d++) begin
        run_req(0, s, d, ROW_BYTES, idx % 3, (idx / 3) % 2, idx % 2, idx % 3);
        idx++;
      end

    // R3 R6: lengths around line and row boundaries, both modes and both kinds
    foreach (lens[i]) begin
      run_req(0, 1, 2, lens[i], 1, 0, 2, 1);
      run_req(0, 1, 9, lens[i], 0, 2, 1, 0);
      run_req(1, 0, 5, lens[i], 2, 1, 0, 2);
      run_req(1, 7, 14, lens[i], 0, 0, 0, 1);
    end

    // R3: crossing a subarray boundary and wrapping the row space
    run_req(0, 2, 6, 3 * ROW_BYTES, 1, 1, 1, 0);
    run_req(0, 14, 15, 2 * ROW_BYTES + 10, 0, 1, 0, 1);
    run_req(1, 0, 15, 2 * ROW_BYTES, 1, 0, 1, 0);

    // R7: long gaps
    run_req(0, 4, 5, ROW_BYTES, 15, 15, 15, 3);
    run_req(0, 4, 12, ROW_BYTES + 64, 15, 7, 11, 0);

    // R9: empty requests
    run_req(0, 3, 4, 0, 1, 1, 1, 0);
    run_req(1, 3, 4, 0, 0, 0, 0, 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule